// File: doc/BRIEF.md
# Two-Level Rotating Bus Arbiter

This block decides which of ten masters may drive a shared parallel bus next. Index 0 is the bridge's own request path; indices 1 to 9 are external masters. Requests and grants are active low, one line per master. A ten-bit group-select input puts every master in either the high group or the low group. The high group takes turns in index order. The low group as a whole holds a single position in that rotation, and it keeps its own rotation among its members.

The arbiter watches the bus framing and ready strobes. It treats the bus as idle when both are high, and it changes the grant only while the bus is idle. A handover always takes two clock edges: the first edge removes the old grant, and the second raises the new one. So two grants never overlap and never swap in a single cycle. When nobody is requesting, the bus is parked on a fixed default master (parameter `PARK_IDX`, default 0).

Top module: `two_level_bus_arbiter`

## Requirements
- R1: While `rst_n` is low, and right after reset, every bit of `gnt_n` is 1.
- R2: At most one bit of `gnt_n` is 0 in any cycle.
- R3: A grant never passes directly from one master to another. At least one cycle with `gnt_n` all ones separates two different grants.
- R4: While the bus is busy (`frame_n` or `irdy_n` low), `gnt_n` keeps its value.
- R5: If the bus is idle, no grant is out and no master requests, `gnt_n[PARK_IDX]` goes low at the next edge. It stays low while no master requests.
- R6: A newly raised grant, other than the park grant, goes to a master whose `req_n` bit was 0 at the deciding edge.
- R7: High-group masters that request continuously are served in ascending index order, wrapping from the highest index back to the lowest.
- R8: All low-group masters together take one position in the high rotation, placed after index 9. With high masters 1 and 2 and low masters requesting, the order is 1, 2, one low master, and then again.
- R9: Each time the low group wins, it serves the next requesting low master after the one it served last, in ascending index order with wraparound.
- R10: If the grant holder's `req_n` goes high while the bus is idle, the grant is removed at the next edge. If nobody else requests, the park grant follows one edge later.
- R11: `grp_hi[i]` = 1 places master i in the high group, and 0 places it in the low group. `req_n[i]` and `gnt_n[i]` belong to master i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_n | input | N_REQ | Request per master, active low |
| grp_hi | input | N_REQ | Group select per master, 1 = high group |
| frame_n | input | 1 | Bus framing strobe, active low |
| irdy_n | input | 1 | Initiator ready strobe, active low |
| gnt_n | output | N_REQ | Grant per master, active low |

## Verification
The bench records the sequence of grants under steady request patterns. An arbiter that let a low master take a full position of its own, or that failed to advance the low pointer, would produce a different order. A monitor watches every cycle for a grant that jumps straight to another master, which an arbiter without the empty handover cycle would do. Other tests start a transaction and add a request mid-transfer, withdraw a request from the holder, and flip the group bits. These catch an arbiter that re-arbitrates on a busy bus, keeps a dead grant, or decodes the group bit inverted.

// File: rtl/arb2_pkg.sv
// Package: shared types for the two-level bus arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package arb2_pkg;

    // Grant sequencer state: no grant, grant to a requester, or parked grant
    typedef enum logic [1:0] {
        GS_NONE  = 2'd0,
        GS_OWNED = 2'd1,
        GS_PARK  = 2'd2
    } gnt_state_e;

endpackage

// File: rtl/arb_rr_pick.sv
// Module: arb_rr_pick
// Combinational round-robin search. Returns the first set bit of elig,
// starting at position ptr and wrapping past W-1 to 0.
// Assumes: ptr < W.
module arb_rr_pick #(
    parameter int W  = 10,
    parameter int IW = 4
) (
    input  logic [W-1:0]  elig,
    input  logic [IW-1:0] ptr,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Scan W positions from ptr and keep the first eligible one
    always_comb begin
        int c;
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < W; k++) begin
            c = int'(ptr) + k;
            if (c >= W) c = c - W;
            if (!found && elig[c]) begin
                found = 1'b1;
                idx   = c[IW-1:0];
            end
        end
    end

endmodule

// File: rtl/arb_grant_seq.sv
// Module: arb_grant_seq
// Holds the current grant. It changes the grant only on idle-bus edges and
// always inserts an empty cycle between two different owners. It parks on
// PARK_IDX when nobody requests. It pulses issue when a grant is given to
// the current winner, so the caller can advance the rotation pointers.
// Assumes: win_idx is valid whenever any_req is high.
module arb_grant_seq
    import arb2_pkg::*;
#(
    parameter int N_REQ    = 10,
    parameter int IW       = 4,
    parameter int PARK_IDX = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idle,
    input  logic          any_req,
    input  logic [IW-1:0] win_idx,
    output logic          gnt_vld,
    output logic [IW-1:0] gnt_idx,
    output logic          issue
);

    localparam logic [IW-1:0] PARK = IW'(PARK_IDX);

    gnt_state_e state;

    // Give a new grant from the empty state, or turn a park into a real grant
    always_comb begin
        issue = idle && any_req &&
                ((state == GS_NONE) || (state == GS_PARK && win_idx == gnt_idx));
    end

    // Move the grant state on idle-bus edges only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= GS_NONE;
            gnt_idx <= '0;
        end else if (idle) begin
            case (state)
                GS_NONE: begin
                    if (any_req) begin
                        state   <= GS_OWNED;
                        gnt_idx <= win_idx;
                    end else begin
                        state   <= GS_PARK;
                        gnt_idx <= PARK;
                    end
                end
                GS_OWNED: begin
                    if (!any_req || win_idx != gnt_idx) state <= GS_NONE;
                end
                GS_PARK: begin
                    if (any_req) begin
                        if (win_idx == gnt_idx) state <= GS_OWNED;
                        else                    state <= GS_NONE;
                    end
                end
                default: state <= GS_NONE;
            endcase
        end
    end

    assign gnt_vld = (state != GS_NONE);

    // R3: an owner never changes while a grant stays out
    a_r3_no_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld && $past(gnt_vld)) |-> (gnt_idx == $past(gnt_idx)));

    // R4: a busy bus freezes the grant
    a_r4_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> ($stable(gnt_vld) && $stable(gnt_idx)));

    // R5: an idle, requestless bus with no grant gets parked
    a_r5_park: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !gnt_vld && !any_req) |=> (gnt_vld && gnt_idx == PARK));

    // R10: the holder loses the grant once all requests vanish
    a_r10_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && state == GS_OWNED && !any_req) |=> !gnt_vld);

endmodule

// File: rtl/two_level_bus_arbiter.sv
// Module: two_level_bus_arbiter (top)
// Two-level rotating arbiter for N_REQ masters. The high ring has N_REQ+1
// positions: one per high-group master plus a single slot for the whole low
// group at position N_REQ. A second ring rotates among the low group.
// Pointers move only when a grant is issued.
// Assumes: bus idle means frame_n and irdy_n both high; inputs are synchronous.
module two_level_bus_arbiter #(
    parameter int N_REQ    = 10,
    parameter int PARK_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_n,
    input  logic [N_REQ-1:0] grp_hi,
    input  logic             frame_n,
    input  logic             irdy_n,
    output logic [N_REQ-1:0] gnt_n
);

    localparam int HW = N_REQ + 1;
    localparam int IW = $clog2(HW);
    localparam logic [IW-1:0] LO_SLOT = IW'(N_REQ);

    logic [N_REQ-1:0] req, lo_elig;
    logic [HW-1:0]    hi_elig;
    logic [IW-1:0]    hi_ptr, lo_ptr, hi_idx, lo_idx, win_idx, gnt_idx;
    logic             hi_found, lo_found, win_low, any_req, idle, gnt_vld, issue;

    // Split active requests into the two rings
    always_comb begin
        req     = ~req_n;
        lo_elig = req & ~grp_hi;
        hi_elig = {|lo_elig, req & grp_hi};
        idle    = frame_n && irdy_n;
    end

    arb_rr_pick #(.W(HW), .IW(IW)) u_hi (
        .elig(hi_elig), .ptr(hi_ptr), .found(hi_found), .idx(hi_idx));

    arb_rr_pick #(.W(N_REQ), .IW(IW)) u_lo (
        .elig(lo_elig), .ptr(lo_ptr), .found(lo_found), .idx(lo_idx));

    // Resolve the final winner through the low slot when it wins
    always_comb begin
        win_low = (hi_idx == LO_SLOT);
        win_idx = win_low ? lo_idx : hi_idx;
        any_req = hi_found && (!win_low || lo_found);
    end

    arb_grant_seq #(.N_REQ(N_REQ), .IW(IW), .PARK_IDX(PARK_IDX)) u_seq (
        .clk(clk), .rst_n(rst_n), .idle(idle), .any_req(any_req),
        .win_idx(win_idx), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx), .issue(issue));

    // Advance the rings past the position just served
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_ptr <= '0;
            lo_ptr <= '0;
        end else if (issue) begin
            hi_ptr <= (hi_idx == IW'(HW - 1)) ? '0 : hi_idx + 1'b1;
            if (win_low)
                lo_ptr <= (lo_idx == IW'(N_REQ - 1)) ? '0 : lo_idx + 1'b1;
        end
    end

    // Decode the held grant onto the active-low lines
    always_comb begin
        gnt_n = '1;
        if (gnt_vld) gnt_n[gnt_idx] = 1'b0;
    end

    // R6: a fresh non-park grant lands on a master that was requesting
    a_r6_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld && !$past(gnt_vld) && gnt_idx != IW'(PARK_IDX))
        |-> (|(~$past(req_n) & ~gnt_n)));

endmodule

// File: tb/sim_two_level_bus_arbiter.sv
// Directed bench for two_level_bus_arbiter: one task per scenario.
module sim_two_level_bus_arbiter;

    localparam int N = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_n = '1;
    logic [N-1:0] grp_hi = 10'b0000000001;
    logic         frame_n = 1'b1;
    logic         irdy_n = 1'b1;
    logic [N-1:0] gnt_n;

    int n_tests = 0;
    int n_fail  = 0;
    int r2_err  = 0;
    int r3_err  = 0;
    int prev_g  = -1;
    bit done    = 1'b0;

    two_level_bus_arbiter #(.N_REQ(N), .PARK_IDX(0)) u0 (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .grp_hi(grp_hi),
        .frame_n(frame_n), .irdy_n(irdy_n), .gnt_n(gnt_n));

    always #5 clk = ~clk;

    // Grant index from the active-low lines, -1 when none
    function automatic int gidx(input logic [N-1:0] g);
        int r = -1;
        for (int i = N - 1; i >= 0; i--) if (!g[i]) r = i;
        return r;
    endfunction

    // Monitor for R2 (one grant) and R3 (empty cycle between owners)
    always @(negedge clk) begin
        if (rst_n) begin
            if ($countones(~gnt_n) > 1) r2_err++;
            if (gidx(gnt_n) >= 0 && prev_g >= 0 && gidx(gnt_n) != prev_g) r3_err++;
            prev_g = gidx(gnt_n);
        end else prev_g = -1;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [N-1:0] rq, input logic [N-1:0] gp);
        @(negedge clk);
        rst_n = 1'b0; req_n = rq; grp_hi = gp; frame_n = 1'b1; irdy_n = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Record the next n grants that follow an empty cycle
    task automatic collect(input int n, output int got[12]);
        int k = 0;
        bit prev_idle = 1'b1;
        for (int i = 0; i < 12; i++) got[i] = -1;
        for (int c = 0; c < 200 && k < n; c++) begin
            @(negedge clk);
            if (gidx(gnt_n) >= 0 && prev_idle) begin
                got[k] = gidx(gnt_n);
                k++;
            end
            prev_idle = (gidx(gnt_n) < 0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset gnt_n", int'(gnt_n), 10'h3FF);
    endtask

    task automatic t_park();
        do_reset('1, 10'b0000000001);
        @(negedge clk);
        check("R5 park after reset", gidx(gnt_n), 0);
        repeat (3) @(negedge clk);
        check("R5 park held", gidx(gnt_n), 0);
        req_n[3] = 1'b0;
        @(negedge clk);
        check("R3 empty cycle after park", gidx(gnt_n), -1);
        @(negedge clk);
        check("R6 grant to requester 3", gidx(gnt_n), 3);
    endtask

    task automatic t_high_rr();
        int got[12];
        int exp[6] = '{1, 2, 3, 1, 2, 3};
        do_reset(10'b1111110001, 10'b0000001111);
        collect(6, got);
        for (int i = 0; i < 6; i++) check("R7 high rotation", got[i], exp[i]);
    endtask

    task automatic t_two_level();
        int got[12];
        int exp[9] = '{1, 2, 5, 1, 2, 7, 1, 2, 5};
        do_reset(10'b1101011001, 10'b0000000111);
        collect(9, got);
        for (int i = 0; i < 9; i++) check("R8 low slot as one entry", got[i], exp[i]);
    endtask

    task automatic t_low_rr();
        int got[12];
        int exp[4] = '{3, 6, 9, 3};
        do_reset(10'b0110110111, 10'b0000000000);
        collect(4, got);
        for (int i = 0; i < 4; i++) check("R9 low rotation", got[i], exp[i]);
    endtask

    task automatic t_withdraw();
        do_reset(10'b1111101111, 10'b0000000001);
        @(negedge clk);
        check("R10 sole requester granted", gidx(gnt_n), 4);
        repeat (3) @(negedge clk);
        check("R10 sole requester keeps grant", gidx(gnt_n), 4);
        req_n[4] = 1'b1;
        @(negedge clk);
        check("R10 grant removed", gidx(gnt_n), -1);
        @(negedge clk);
        check("R10 park follows", gidx(gnt_n), 0);
    endtask

    task automatic t_busy();
        do_reset(10'b1111101111, 10'b0000000001);
        @(negedge clk);
        check("R4 initial grant", gidx(gnt_n), 4);
        frame_n = 1'b0; irdy_n = 1'b0; req_n[7] = 1'b0;
        repeat (4) @(negedge clk);
        check("R4 grant frozen while busy", gidx(gnt_n), 4);
        frame_n = 1'b1; irdy_n = 1'b1;
        @(negedge clk);
        check("R4 handover starts when idle", gidx(gnt_n), -1);
        @(negedge clk);
        check("R4 next owner", gidx(gnt_n), 7);
    endtask

    task automatic t_group_bit();
        int got[12];
        do_reset(10'b1011111011, 10'b0100000000);
        collect(3, got);
        check("R11 high member 8 first", got[0], 8);
        check("R11 low member 2 next", got[1], 2);
        check("R11 high member 8 again", got[2], 8);
        do_reset(10'b1011111011, 10'b0000000000);
        collect(3, got);
        check("R11 all low order", got[0], 2);
        check("R11 all low order", got[1], 8);
        check("R11 all low order", got[2], 2);
    endtask

    initial begin
        t_reset();
        t_park();
        t_high_rr();
        t_two_level();
        t_low_rr();
        t_withdraw();
        t_busy();
        t_group_bit();
        check("R2 single grant per cycle", r2_err, 0);
        check("R3 no direct handover", r3_err, 0);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule